// File: doc/BRIEF.md
# Two-Class Round-Robin Bus Arbiter with Wait-Based Promotion

This block decides which of several requesters owns a shared on-chip bus in the next cycle. Each pending request has an effective priority, low or high. Any high request beats every low request. Within each class, the winner is chosen round-robin from a pointer that the class keeps for itself.

Most requesters are promoted by a central timer. A request from such a requester starts at low priority and turns high once it has waited a programmed number of 16-cycle steps without being granted. The step count comes from a 5-bit field per requester in a single raise register, which software writes through a plain write port. The remaining requesters bypass the timers and present their own priority on a per-requester priority line.

The grant is registered and one-hot. A parallel registered bit reports whether the winning request was high. The combinational effective priority of every requester is also visible at the ports.

Top module: `arb_dual_rr`

## Requirements
- R1: `gnt_o` is registered: the value in cycle t+1 is decided from the inputs and state in cycle t. It has at most one bit set, and it is all zero when no request was pending in cycle t.
- R2: When any request is effectively high, the grant goes to a high request. `gnt_hi_o` is set together with such a grant.
- R3: Each class has its own pointer, starting at requester 0 after reset. The class winner is the first pending member at or after that pointer, searching with wrap-around. The pointer then moves to the position after that winner, and the other class pointer is left alone.
- R4: A centrally timed requester whose delay field is 0 is effectively high in the first cycle it requests.
- R5: A centrally timed requester with delay field D that requests continuously without a grant is low for its first 16*D cycles and high from cycle 16*D on, counting its first requesting cycle as cycle 0. It stays high until it is granted or withdraws.
- R6: A grant or a withdrawn request (req low for a cycle) ends the wait. The next request starts again at cycle 0.
- R7: Centrally timed requester k (k = 0..3) uses raise-register bits [5k+4:5k].
- R8: A wait uses the delay field value in force in its cycle 0. A write during the wait does not change that wait. It applies to waits that start afterwards.
- R9: `prio_i` is ignored for centrally timed requesters. Requester 4 is effectively high exactly when it requests with `prio_i[4]` = 1.
- R10: Reset (active low) clears the grant, `gnt_hi_o`, both pointers, all timers and the raise register, so every timed request is high at once.
- R11: `gnt_hi_o` is 1 in the cycle a high request's grant is shown, and 0 with a low-class grant or no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 5 | Request line per requester |
| prio_i | input | 5 | Requested priority (1 = high); used only by self-prioritised requesters |
| cfg_we_i | input | 1 | Raise-register write enable |
| cfg_wdata_i | input | 20 | Raise-register write data, four 5-bit delay fields |
| gnt_o | output | 5 | Registered one-hot grant |
| gnt_hi_o | output | 1 | Registered: the current grant went to a high request |
| eff_hi_o | output | 5 | Combinational effective high priority per pending requester |

## Verification
`eff_hi_o` is combinational from the current requests and the timer registers. It is therefore checked in the same cycle as the stimulus, once the inputs settle. `gnt_o` and `gnt_hi_o` pass through one register, so they are checked at the falling edge after the rising edge that follows the stimulus. Promotion timing is counted in falling edges from a request's first cycle. The checks look just before and exactly at the 16*D boundary, and at the grant that follows one edge later. Inputs change only at falling edges, so every sample sits half a period away from the edge that moves the design.

// File: rtl/arb_pkg.sv
// Shared helpers for the two-class arbiter.
// Assumes index values below 2**31.
package arb_pkg;

    // Priority classes; the numeric value indexes per-class state.
    typedef enum logic {
        CLS_LO = 1'b0,
        CLS_HI = 1'b1
    } arb_cls_e;

    // Position after idx in a ring of n slots.
    function automatic int wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_raise_timer.sv
// Wait timer for one centrally promoted requester.
// Counts cycles of an ungranted request and reports effective high once the
// count reaches the delay field times 2**STEP_LOG2. The field is latched in
// the first waiting cycle. Assumes win_i is the grant decision of this cycle.
module arb_raise_timer #(
    parameter int DELAY_W   = 5,
    parameter int STEP_LOG2 = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               win_i,
    input  logic [DELAY_W-1:0] field_i,
    output logic               hi_o
);
    localparam int CNT_W = DELAY_W + STEP_LOG2;

    logic               waiting_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DELAY_W-1:0] lim_q;
    logic [DELAY_W-1:0] limit;
    logic [CNT_W-1:0]   thresh;
    logic [CNT_W-1:0]   elapsed;

    // Effective priority from the elapsed wait and the active delay.
    always_comb begin
        limit   = waiting_q ? lim_q : field_i;
        thresh  = {limit, {STEP_LOG2{1'b0}}};
        elapsed = waiting_q ? cnt_q : '0;
        hi_o    = req_i && (elapsed >= thresh);
    end

    // Start, advance or end the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            cnt_q     <= '0;
            lim_q     <= '0;
        end else if (!req_i || win_i) begin
            waiting_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!waiting_q) begin
            waiting_q <= 1'b1;
            cnt_q     <= CNT_W'(1);
            lim_q     <= field_i;
        end else if (cnt_q != '1) begin
            cnt_q     <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
// Round-robin search: the first set bit of vec_i at or after ptr_i, with
// wrap-around. Purely combinational. Assumes ptr_i < N.
module arb_rr_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    int cand;

    // Scan from the pointer around the ring.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        cand    = 0;
        for (int off = 0; off < N; off++) begin
            cand = int'(ptr_i) + off;
            if (cand >= N) cand = cand - N;
            if (!found_o && vec_i[cand]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_dual_rr.sv
// Two-class round-robin bus arbiter with wait-based promotion.
// Requesters 0..NUM_CENTRAL-1 are promoted by timers driven from the raise
// register. The rest take their priority from prio_i. High beats low, and each
// class rotates its own pointer. Assumes NUM_CENTRAL < NUM_REQ.
module arb_dual_rr
    import arb_pkg::*;
#(
    parameter int NUM_REQ     = 5,
    parameter int NUM_CENTRAL = 4,
    parameter int DELAY_W     = 5,
    parameter int STEP_LOG2   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REQ-1:0]             req_i,
    input  logic [NUM_REQ-1:0]             prio_i,
    input  logic                           cfg_we_i,
    input  logic [NUM_CENTRAL*DELAY_W-1:0] cfg_wdata_i,
    output logic [NUM_REQ-1:0]             gnt_o,
    output logic                           gnt_hi_o,
    output logic [NUM_REQ-1:0]             eff_hi_o
);
    localparam int RAISE_W = NUM_CENTRAL * DELAY_W;
    localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int NUM_CLS = 2;

    logic [RAISE_W-1:0] raise_q;
    logic [NUM_REQ-1:0] eff_hi;
    logic [NUM_REQ-1:0] gnt_next;
    logic [NUM_REQ-1:0] cls_vec [NUM_CLS];
    logic [IDX_W-1:0]   ptr_q   [NUM_CLS];
    logic [IDX_W-1:0]   pick_idx[NUM_CLS];
    logic [NUM_CLS-1:0] pick_found;
    arb_cls_e           win_cls;
    logic [IDX_W-1:0]   win_idx;
    logic               any_win;

    // Raise register: plain write port.
    always_ff @(posedge clk) begin
        if (!rst_n) raise_q <= '0;
        else if (cfg_we_i) raise_q <= cfg_wdata_i;
    end

    // Effective priority source per requester.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_src
        if (i < NUM_CENTRAL) begin : g_timed
            arb_raise_timer #(
                .DELAY_W  (DELAY_W),
                .STEP_LOG2(STEP_LOG2)
            ) timer_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req_i[i]),
                .win_i  (gnt_next[i]),
                .field_i(raise_q[i*DELAY_W +: DELAY_W]),
                .hi_o   (eff_hi[i])
            );
        end else begin : g_self
            assign eff_hi[i] = req_i[i] & prio_i[i];
        end
    end

    assign eff_hi_o = eff_hi;

    // One round-robin search per class.
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign cls_vec[c] = (c == int'(CLS_HI)) ? (req_i & eff_hi) : (req_i & ~eff_hi);
        arb_rr_pick #(
            .N    (NUM_REQ),
            .IDX_W(IDX_W)
        ) pick_i (
            .vec_i  (cls_vec[c]),
            .ptr_i  (ptr_q[c]),
            .found_o(pick_found[c]),
            .idx_o  (pick_idx[c])
        );
    end

    // Pick the class, then the requester, and form the next grant.
    always_comb begin
        win_cls  = pick_found[CLS_HI] ? CLS_HI : CLS_LO;
        win_idx  = pick_idx[win_cls];
        any_win  = |pick_found;
        gnt_next = any_win ? (NUM_REQ'(1) << win_idx) : '0;
    end

    // Register the grant and move the winning class pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_o    <= '0;
            gnt_hi_o <= 1'b0;
            for (int c = 0; c < NUM_CLS; c++) ptr_q[c] <= '0;
        end else begin
            gnt_o    <= gnt_next;
            gnt_hi_o <= pick_found[CLS_HI];
            if (any_win) ptr_q[win_cls] <= IDX_W'(wrap_inc(int'(win_idx), NUM_REQ));
        end
    end
endmodule

// File: rtl/arb_dual_rr_chk.sv
// Port-level temporal checks for arb_dual_rr, attached by bind.
module arb_dual_rr_chk #(
    parameter int NUM_REQ     = 5,
    parameter int NUM_CENTRAL = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] gnt_o,
    input logic               gnt_hi_o,
    input logic [NUM_REQ-1:0] eff_hi_o
);
    // R1: at most one grant at a time.
    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R1: no pending request means no grant in the next cycle.
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (gnt_o == '0));

    // R1: any pending request yields a grant in the next cycle.
    assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> (gnt_o != '0));

    // R2: a pending high request yields a high grant.
    assert_hi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & eff_hi_o) != '0) |=> gnt_hi_o);

    // R11: the high flag never appears without a grant.
    assert_hi_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_hi_o |-> (gnt_o != '0));

    // R5: once promoted, a timed request stays high while held and ungranted.
    for (genvar i = 0; i < NUM_CENTRAL; i++) begin : g_keep
        assert_keep_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (eff_hi_o[i] && req_i[i]) ##1 (req_i[i] && !gnt_o[i]) |-> eff_hi_o[i]);
    end
endmodule

bind arb_dual_rr arb_dual_rr_chk #(
    .NUM_REQ    (NUM_REQ),
    .NUM_CENTRAL(NUM_CENTRAL)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .gnt_o   (gnt_o),
    .gnt_hi_o(gnt_hi_o),
    .eff_hi_o(eff_hi_o)
);

// File: tb/arb_dual_rr_tb_top.sv
module arb_dual_rr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 5;
    localparam int RW = 20;
    localparam int NV = 12;
    // {req[15:11], prio[10:6], expected gnt[5:1], expected gnt_hi[0]}
    localparam logic [15:0] VEC_TBL [NV] = '{
        {5'b00000, 5'b00000, 5'b00000, 1'b0},
        {5'b11111, 5'b00000, 5'b00001, 1'b1},
        {5'b11111, 5'b00000, 5'b00010, 1'b1},
        {5'b11111, 5'b00000, 5'b00100, 1'b1},
        {5'b11111, 5'b00000, 5'b01000, 1'b1},
        {5'b11111, 5'b00000, 5'b00001, 1'b1},
        {5'b10000, 5'b10000, 5'b10000, 1'b1},
        {5'b10000, 5'b00000, 5'b10000, 1'b0},
        {5'b10100, 5'b10000, 5'b00100, 1'b1},
        {5'b10100, 5'b10000, 5'b10000, 1'b1},
        {5'b01000, 5'b00000, 5'b01000, 1'b1},
        {5'b11000, 5'b01111, 5'b01000, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  prio = '0;
    logic          cfg_we = 1'b0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [N-1:0]  gnt;
    logic          gnt_hi;
    logic [N-1:0]  eff_hi;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arb_dual_rr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .prio_i     (prio),
        .cfg_we_i   (cfg_we),
        .cfg_wdata_i(cfg_wdata),
        .gnt_o      (gnt),
        .gnt_hi_o   (gnt_hi),
        .eff_hi_o   (eff_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Write the raise register for one cycle (called at a falling edge).
    task automatic write_raise(input logic [RW-1:0] val);
        cfg_we = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 gnt after reset", 32'(gnt), 0);
        chk("R10 gnt_hi after reset", 32'(gnt_hi), 0);

        // Table: R1 R2 R3 R9 R10 R11 (raise register still zero)
        for (int v = 0; v < NV; v++) begin
            req  = VEC_TBL[v][15:11];
            prio = VEC_TBL[v][10:6];
            @(negedge clk);
            chk("R1/R2/R3 grant", 32'(gnt), 32'(VEC_TBL[v][5:1]));
            chk("R11 grant class", 32'(gnt_hi), 32'(VEC_TBL[v][0]));
        end
        req = '0; prio = '0;
        @(negedge clk);
        chk("R1 no grant when idle", 32'(gnt), 0);

        // R5 R7: requester 1 gets 2 steps (32 cycles), bits 9:5
        write_raise(RW'(2) << 5);
        req = 5'b00011;
        #1;
        chk("R5 cycle 0 low", 32'(eff_hi[1]), 0);
        for (int k = 1; k <= 33; k++) begin
            @(negedge clk);
            if (k == 1)  chk("R7 field of req0 is zero", 32'(eff_hi[0]), 1);
            if (k == 31) chk("R5 low before boundary", 32'(eff_hi[1]), 0);
            if (k == 32) begin
                chk("R5 high at boundary", 32'(eff_hi[1]), 1);
                chk("R2 req0 still granted", 32'(gnt), 32'b00001);
            end
            if (k == 33) begin
                chk("R3 promoted req1 granted", 32'(gnt), 32'b00010);
                chk("R6 wait ends on grant", 32'(eff_hi[1]), 0);
            end
        end

        // R8: field changes to 0 in the wait's first cycle; old value holds
        req = '0;
        @(negedge clk);
        req = 5'b00011;
        cfg_we = 1'b1;
        cfg_wdata = '0;
        #1;
        chk("R8 cycle 0 uses old field", 32'(eff_hi[1]), 0);
        for (int k = 1; k <= 33; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (k == 1)  chk("R8 latched field kept", 32'(eff_hi[1]), 0);
            if (k == 31) chk("R8 still low", 32'(eff_hi[1]), 0);
            if (k == 32) chk("R8 high at latched boundary", 32'(eff_hi[1]), 1);
            if (k == 33) begin
                chk("R8 grant to req1", 32'(gnt), 32'b00010);
                chk("R8 new field applies to next wait", 32'(eff_hi[1]), 1);
            end
        end

        // R6: withdraw restarts the wait (field 1 = 16 cycles)
        req = '0;
        write_raise(RW'(1) << 5);
        req = 5'b00011;
        repeat (10) @(negedge clk);
        req = 5'b00001;
        @(negedge clk);
        req = 5'b00011;
        #1;
        chk("R6 restart low", 32'(eff_hi[1]), 0);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 15) chk("R6 low before new boundary", 32'(eff_hi[1]), 0);
            if (k == 16) chk("R6 high at new boundary", 32'(eff_hi[1]), 1);
        end

        // R4 R9: zero field is immediate, prio ignored for timed, self follows prio
        req = '0;
        @(negedge clk);
        req = 5'b10100;
        prio = 5'b10000;
        #1;
        chk("R4 zero field high at once", 32'(eff_hi[2]), 1);
        chk("R9 self requester high", 32'(eff_hi[4]), 1);
        prio = 5'b00100;
        #1;
        chk("R9 self requester low", 32'(eff_hi[4]), 0);
        chk("R9 prio ignored for timed", 32'(eff_hi[2]), 1);
        @(negedge clk);
        chk("R11 high grant flag", 32'(gnt_hi), 1);
        req = '0; prio = '0;
        @(negedge clk);
        chk("R11 flag clear when idle", 32'(gnt_hi), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule